// File: doc/BRIEF.md
# Shared Cache-Maintenance Command Registrar

This block sits between several bus masters and a single cache-maintenance engine. Masters describe a maintenance command through a small set of shared registers: mode, start address, length and way mask. The registrar arbitrates who may fill those registers, then commits the finished command into a FIFO that the engine drains through a valid/ready command port.

The first master to write the mode register becomes the owner. It keeps ownership until it reads its set-status register. That read tells the master whether the command went in. A master that gets a failure code repeats its whole write sequence. Every master has its own status: whether its last registration failed, whether it has commands pending, and a completion flag. The engine returns completions tagged with the issuing master, and only that master's flag changes.

A separate primitive register accepts two codes. Code 8 starts a drain barrier. Code 9 pulses a prefetch-buffer flush request. A read of the primitive register issued while a barrier is open stalls on the bus until every registered command has been completed by the engine.

Top module: `cmq_registrar`

## Requirements
- R1: The first master to write the mode register (offset 0) while no owner exists becomes the owner. Mode, address (offset 1), size (offset 2) and way (offset 3) writes from any other master are ignored while ownership is held.
- R2: When the owner reads its set-status register (offset 4), ownership is released. Another master can then claim it.
- R3: A successful owner set-status read returns 0 and pushes one command. The command's mode keeps only bits [2:0] (opcode), bit 15 (notify), [18:17] (scope) and [22:21] (target). Its address and size are the written values when scope is 0 and zero otherwise. Its way mask is the written value when target is 2 and zero otherwise. Its master field is the owner's ID.
- R4: When the FIFO holds FIFO_DEPTH commands, the owner's set-status read returns 3 (bit 1 full, bit 0 failed). Nothing is pushed, and ownership is still released.
- R5: A set-status read by a master that does not own the registers returns 1.
- R6: The queue-status register (offset 5) of each master reads {completion, error, busy} in bits [2:0]. Busy is set while that master has commands queued or not yet completed. Error is set when that master's last set-status read failed.
- R7: A completion input with done_notify set raises bit 2 only for the master named by done_master. A write to offset 5 with bit 2 set clears that bit for the writing master.
- R8: After code 8 is written to the primitive register (offset 6), a read of offset 6 is held with req_ready low until every registered command has been completed.
- R9: A write of code 9 (bits [3:0]) to offset 6 pulses pf_flush for exactly one cycle, in the cycle after the write. No other write causes a pulse.
- R10: Every accepted read returns its data with rsp_valid in the cycle after acceptance. rsp_valid is low otherwise.
- R11: Commands leave the FIFO in registration order, and the command port holds its payload stable while cmd_valid is high and cmd_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | ID_W | Issuing master |
| req_addr | input | 3 | Register word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cmd_valid | output | 1 | Command available to engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_mode | output | 32 | Filtered mode word |
| cmd_addr | output | ADDR_W | Range start |
| cmd_size | output | ADDR_W | Range length |
| cmd_ways | output | NUM_WAYS | Target way mask |
| cmd_master | output | ID_W | Issuing master tag |
| done_valid | input | 1 | Engine finished one command |
| done_master | input | ID_W | Tag of finished command |
| done_notify | input | 1 | Finished command asked for notification |
| pf_flush | output | 1 | Prefetch-buffer flush pulse |

## Verification
A corrupted owner record shows up at the very next set-status read: a master gets 1 where it expected 0. The command also goes missing from, or appears unexpectedly on, the engine port in the following cycle. A wrong per-master outstanding count first appears as a stuck or missing busy bit in queue status. It later appears as a barrier read that never releases or releases too early. The bench compares every popped command field against a model queue, so a dropped, duplicated or reordered FIFO entry is caught on the first pop after it.

// File: rtl/cmq_registrar.sv
module cmq_registrar #(
  parameter int NUM_MASTERS = 4,
  parameter int FIFO_DEPTH  = 4,
  parameter int ADDR_W      = 32,
  parameter int NUM_WAYS    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [((NUM_MASTERS>1)?$clog2(NUM_MASTERS):1)-1:0] req_id,
  input  logic [2:0]          req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [31:0]         cmd_mode,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [ADDR_W-1:0]   cmd_size,
  output logic [NUM_WAYS-1:0] cmd_ways,
  output logic [((NUM_MASTERS>1)?$clog2(NUM_MASTERS):1)-1:0] cmd_master,
  input  logic                done_valid,
  input  logic [((NUM_MASTERS>1)?$clog2(NUM_MASTERS):1)-1:0] done_master,
  input  logic                done_notify,
  output logic                pf_flush
);
  localparam int ID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam int PW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW   = $clog2(FIFO_DEPTH + 1);
  localparam int OW   = 8;
  localparam logic [31:0] MODE_MASK = 32'h0066_8007;
  localparam logic [2:0] A_MODE = 3'd0, A_ADDR = 3'd1, A_SIZE = 3'd2, A_WAYS = 3'd3,
                         A_SET = 3'd4, A_QST = 3'd5, A_PRIM = 3'd6;

  logic                own_q;
  logic [ID_W-1:0]     own_id_q;
  logic [31:0]         mode_q;
  logic [ADDR_W-1:0]   addr_q, size_q;
  logic [NUM_WAYS-1:0] ways_q;
  logic [NUM_MASTERS-1:0] ef_q, est_q, busy;
  logic [OW-1:0]       ost_q [NUM_MASTERS];
  logic                sync_q, drained;

  logic [31:0]         f_mode [FIFO_DEPTH];
  logic [ADDR_W-1:0]   f_addr [FIFO_DEPTH];
  logic [ADDR_W-1:0]   f_size [FIFO_DEPTH];
  logic [NUM_WAYS-1:0] f_ways [FIFO_DEPTH];
  logic [ID_W-1:0]     f_id   [FIFO_DEPTH];
  logic [PW-1:0]       wp_q, rp_q;
  logic [CW-1:0]       fifo_cnt;

  always_comb begin
    drained = 1'b1;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      busy[i] = ost_q[i] != '0;
      if (busy[i]) drained = 1'b0;
    end
  end

  assign req_ready = !(req_valid && !req_write && req_addr == A_PRIM && sync_q && !drained);
  wire acc      = req_valid && req_ready;
  wire wr       = acc && req_write;
  wire rd       = acc && !req_write;
  wire is_owner = own_q && own_id_q == req_id;
  wire full     = fifo_cnt == CW'(FIFO_DEPTH);
  wire set_rd   = rd && req_addr == A_SET;
  wire push     = set_rd && is_owner && !full;
  wire pop      = cmd_valid && cmd_ready;
  wire scope_rg = mode_q[18:17] == 2'd0;
  wire tgt_way  = mode_q[22:21] == 2'd2;

  assign cmd_valid  = fifo_cnt != '0;
  assign cmd_mode   = f_mode[rp_q];
  assign cmd_addr   = f_addr[rp_q];
  assign cmd_size   = f_size[rp_q];
  assign cmd_ways   = f_ways[rp_q];
  assign cmd_master = f_id[rp_q];

  logic [31:0] rdata_n;
  always_comb begin
    case (req_addr)
      A_MODE:  rdata_n = mode_q;
      A_ADDR:  rdata_n = 32'(addr_q);
      A_SIZE:  rdata_n = 32'(size_q);
      A_WAYS:  rdata_n = 32'(ways_q);
      A_SET:   rdata_n = is_owner ? (full ? 32'd3 : 32'd0) : 32'd1;
      A_QST:   rdata_n = {29'd0, ef_q[req_id], est_q[req_id], busy[req_id]};
      default: rdata_n = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0; own_id_q <= '0; mode_q <= '0;
      addr_q <= '0; size_q <= '0; ways_q <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; pf_flush <= 1'b0; sync_q <= 1'b0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_n;
      pf_flush <= wr && req_addr == A_PRIM && req_wdata[3:0] == 4'd9;
      if (wr && req_addr == A_PRIM && req_wdata[3:0] == 4'd8) sync_q <= 1'b1;
      else if (drained) sync_q <= 1'b0;
      if (wr && req_addr == A_MODE && !own_q) begin
        own_q <= 1'b1; own_id_q <= req_id; mode_q <= req_wdata & MODE_MASK;
        addr_q <= '0; size_q <= '0; ways_q <= '0;
      end else if (wr && is_owner) begin
        case (req_addr)
          A_MODE: mode_q <= req_wdata & MODE_MASK;
          A_ADDR: addr_q <= ADDR_W'(req_wdata);
          A_SIZE: size_q <= ADDR_W'(req_wdata);
          A_WAYS: ways_q <= req_wdata[NUM_WAYS-1:0];
          default: ;
        endcase
      end
      if (set_rd && is_owner) own_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ef_q <= '0; est_q <= '0;
      for (int i = 0; i < NUM_MASTERS; i++) ost_q[i] <= '0;
    end else begin
      if (set_rd) est_q[req_id] <= !push;
      if (wr && req_addr == A_QST && req_wdata[2]) ef_q[req_id] <= 1'b0;
      if (done_valid && done_notify) ef_q[done_master] <= 1'b1;
      for (int i = 0; i < NUM_MASTERS; i++) begin
        case ({push && own_id_q == ID_W'(i), done_valid && done_master == ID_W'(i) && busy[i]})
          2'b10:   ost_q[i] <= ost_q[i] + 1'b1;
          2'b01:   ost_q[i] <= ost_q[i] - 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; fifo_cnt <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(FIFO_DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(FIFO_DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   fifo_cnt <= fifo_cnt + 1'b1;
        2'b01:   fifo_cnt <= fifo_cnt - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      f_mode[wp_q] <= mode_q;
      f_addr[wp_q] <= scope_rg ? addr_q : '0;
      f_size[wp_q] <= scope_rg ? size_q : '0;
      f_ways[wp_q] <= tgt_way ? ways_q : '0;
      f_id[wp_q]   <= own_id_q;
    end
  end
endmodule

// File: rtl/cmq_registrar_chk.sv
module cmq_registrar_chk #(
  parameter int ID_W = 2,
  parameter int ADDR_W = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [2:0]        req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [31:0]       cmd_mode,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [ID_W-1:0]   cmd_master,
  input logic              pf_flush,
  input logic [CW-1:0]     fifo_cnt
);
  wire acc_rd  = req_valid && req_ready && !req_write;
  wire flush_w = req_valid && req_ready && req_write && req_addr == 3'd6 && req_wdata[3:0] == 4'd9;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_mode) && $stable(cmd_addr) && $stable(cmd_master));
  p_stall_only_prim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> req_valid && !req_write && req_addr == 3'd6);
  p_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n) acc_rd |=> rsp_valid);
  p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n) !acc_rd |=> !rsp_valid);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n) flush_w |=> pf_flush);
  p_no_flush_r9: assert property (@(posedge clk) disable iff (!rst_n) !flush_w |=> !pf_flush);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n) fifo_cnt <= CW'(FIFO_DEPTH));
endmodule

bind cmq_registrar cmq_registrar_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (.*);

// File: tb/sim_cmq_registrar.sv
`timescale 1ns/1ps
module sim_cmq_registrar;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, cmd_ready = 0, done_valid = 0, done_notify = 0;
  logic [1:0] req_id = 0, done_master = 0;
  logic [2:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid, cmd_valid, pf_flush;
  logic [31:0] rsp_rdata, cmd_mode, cmd_addr, cmd_size;
  logic [7:0] cmd_ways;
  logic [1:0] cmd_master;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cmq_registrar u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input int id, input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_id = 2'(id); req_addr = 3'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int id, input int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_id = 2'(id); req_addr = 3'(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    chk(rsp_valid, "R10 rsp_valid", rsp_valid, 1);
  endtask

  task automatic done(input int id, input bit n);
    @(negedge clk);
    done_valid = 1; done_master = 2'(id); done_notify = n;
    @(negedge clk);
    done_valid = 0; done_notify = 0;
  endtask

  task automatic pop1();
    @(negedge clk); cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
  endtask

  function automatic logic [31:0] exp_mode(input logic [31:0] m);
    return m & 32'h0066_8007;
  endfunction

  logic [31:0] q_mode [16], q_addr [16], q_size [16];
  logic [7:0]  q_ways [16];
  int          q_id [16];

  initial begin
    #(8ns * 200000);
    fails++; $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cmd_valid && req_ready && !pf_flush && !rsp_valid, "reset outputs", cmd_valid, 0);
    rd(0, 5, d); chk(d == 0, "R6 reset qstat", d, 0);

    rd(1, 4, d); chk(d == 1, "R5 non-owner set-status", d, 1);
    rd(1, 5, d); chk(d == 2, "R6 error bit", d, 2);

    wr(0, 0, 32'h4000_8002);
    wr(2, 0, 32'h1);
    wr(2, 1, 32'hdead);
    wr(0, 1, 32'h1000); wr(0, 2, 32'h40); wr(0, 3, 32'hFF);
    rd(0, 0, d); chk(d == 32'h8002, "R3 mode filtered", d, 32'h8002);
    rd(2, 4, d); chk(d == 1, "R1 other master fails", d, 1);
    rd(0, 4, d); chk(d == 0, "R2 owner release ok", d, 0);
    chk(cmd_valid && cmd_mode == 32'h8002 && cmd_addr == 32'h1000 && cmd_size == 32'h40
        && cmd_ways == 0 && cmd_master == 0, "R3 command fields", cmd_addr, 32'h1000);
    rd(0, 5, d); chk(d == 1, "R6 busy", d, 1);

    wr(2, 0, 32'h0042_0005); wr(2, 1, 32'h55); wr(2, 3, 32'h0F);
    rd(2, 4, d); chk(d == 0, "R2 reclaim", d, 0);
    pop1();
    chk(cmd_valid && cmd_mode == 32'h0042_0005 && cmd_addr == 0 && cmd_size == 0
        && cmd_ways == 8'h0F && cmd_master == 2, "R3 gated fields", cmd_ways, 8'h0F);
    pop1();
    chk(!cmd_valid, "R11 empty after pops", cmd_valid, 0);

    done(0, 1);
    rd(0, 5, d); chk(d == 4, "R7 completion set", d, 4);
    rd(2, 5, d); chk(d == 1, "R7 other master untouched", d, 1);
    wr(0, 5, 32'h4);
    rd(0, 5, d); chk(d == 0, "R7 clear", d, 0);
    done(2, 0);
    rd(2, 5, d); chk(d == 0, "R7 no notify", d, 0);

    for (int i = 0; i < 4; i++) begin
      wr(3, 0, 32'h2); wr(3, 1, 32'(i * 256));
      rd(3, 4, d); chk(d == 0, "R4 fill", d, 0);
    end
    wr(3, 0, 32'h2);
    rd(3, 4, d); chk(d == 3, "R4 full", d, 3);
    rd(3, 5, d); chk(d == 3, "R6 full error busy", d, 3);
    wr(1, 0, 32'h1);
    rd(1, 4, d); chk(d == 3, "R4 release after full", d, 3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmd_valid && cmd_addr == 32'(i * 256) && cmd_master == 3, "R11 order", cmd_addr, i * 256);
      pop1();
      done(3, 0);
    end

    wr(0, 0, 32'h2);
    rd(0, 4, d);
    wr(0, 6, 32'h8);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_id = 0; req_addr = 3'd6;
    repeat (2) @(negedge clk);
    chk(!req_ready, "R8 stall queued", req_ready, 0);
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
    chk(!req_ready, "R8 stall in engine", req_ready, 0);
    done_valid = 1; done_master = 0; @(negedge clk); done_valid = 0;
    chk(req_ready, "R8 release after done", req_ready, 1);
    @(negedge clk); req_valid = 0;
    chk(rsp_valid, "R10 prim read", rsp_valid, 1);

    wr(1, 6, 32'h9);
    chk(pf_flush, "R9 pulse", pf_flush, 1);
    @(negedge clk); chk(!pf_flush, "R9 single cycle", pf_flush, 0);
    wr(1, 6, 32'h8);
    chk(!pf_flush, "R9 no pulse on sync", pf_flush, 0);
    rd(1, 6, d); chk(d == 0, "R8 no stall when drained", d, 0);

    for (int r = 0; r < 30; r++) begin
      int k, n;
      k = 1 + int'($urandom % 6); n = 0;
      for (int j = 0; j < k; j++) begin
        int m; logic [31:0] md, ad, sz, wy;
        m = int'($urandom % 4); md = $urandom; ad = $urandom; sz = $urandom; wy = $urandom & 32'hFF;
        wr(m, 0, md); wr(m, 1, ad); wr(m, 2, sz); wr(m, 3, wy);
        rd(m, 4, d);
        if (n < 4) begin
          chk(d == 0, "R3 random accept", d, 0);
          q_mode[n] = exp_mode(md);
          q_addr[n] = (md[18:17] == 0) ? ad : 0;
          q_size[n] = (md[18:17] == 0) ? sz : 0;
          q_ways[n] = (md[22:21] == 2) ? wy[7:0] : 0;
          q_id[n] = m; n++;
        end else chk(d == 3, "R4 random full", d, 3);
      end
      for (int j = 0; j < n; j++) begin
        @(negedge clk);
        chk(cmd_valid && cmd_mode == q_mode[j] && cmd_addr == q_addr[j] && cmd_size == q_size[j]
            && cmd_ways == q_ways[j] && cmd_master == 2'(q_id[j]), "R11 random pop", cmd_mode, q_mode[j]);
        pop1();
        done(q_id[j], 1);
        rd(q_id[j], 5, d); chk(d[2] == 1, "R7 random completion", d, 4);
        wr(q_id[j], 5, 32'h4);
      end
      for (int m = 0; m < 4; m++) begin
        rd(m, 5, d); chk(d[0] == 0 && d[2] == 0, "R6 random idle", d, 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule